// File: doc/BRIEF.md
# Write-Back Four-Way Data Cache

This block is a 32 KiB data cache that sits between a processor load/store port and a line-oriented memory port. It holds 128 sets of four ways with 64-byte lines. Reads and writes that hit are served in the cycle the request is presented. Misses are handled one at a time by a small state machine. Stores are write-back with allocate-on-write: a store only marks the line dirty, and a store miss first brings the whole line in and then merges the store bytes into it.

Each way of each set keeps a single access bit. The bit is set whenever the way is hit or refilled. When setting it would leave every bit in the set at one, the other bits of that set are cleared. On a miss, an invalid way is taken first (lowest number first). Otherwise the victim is the lowest-numbered way whose access bit is clear. A dirty victim is sent to memory as an eight-beat burst, and only after that does the eight-beat refill for the requested line begin.

The processor keeps `cpuReq` and all request fields steady until `cpuReady` is seen high at a clock edge. Memory commands use a valid/ready handshake. Write beats use their own valid/ready pair. Read beats carry only a valid, because the cache always accepts them.

Top module: `dcache_top`

## Requirements
- R1: An address is split as byte offset [5:0], word-in-line [5:3], set index [12:6] and tag [31:13]. The cache has 128 sets of 4 ways, and a tag is present in at most one way of its set.
- R2: A read that hits raises `cpuReady` in the cycle of the request, without any memory command. `cpuRData` is then the 64-bit word at the address, reflecting every earlier store.
- R3: A write that hits updates only the bytes whose `cpuByteEn` bit is set (bit n covers data bits [8n+7:8n]), marks the line dirty and issues no memory traffic.
- R4: On a miss, `cpuReady` stays low through the write-back and refill phases and rises only in the response phase.
- R5: A write miss first refills the line from memory and then merges the enabled bytes, so the untouched bytes of the line keep the memory values.
- R6: A refill issues one read command (`memCmdWrite`=0) whose address is the line-aligned request address. It then takes eight beats in ascending word order, and in the response phase the request hits.
- R7: A dirty victim is written back with one write command (`memCmdWrite`=1) at the victim's line-aligned address, followed by eight ascending beats. All eight beats finish before the refill command appears.
- R8: A clean or invalid victim causes no write command.
- R9: When a set holds an invalid way, the victim is the lowest-numbered invalid way.
- R10: A hit or a refill sets the access bit of its way. When all ways are valid, the victim is the lowest-numbered way whose access bit is clear.
- R11: When setting an access bit would make all four bits of a set one, the other three are cleared instead.
- R12: A synchronous reset clears every valid, dirty and access bit. After reset every access misses and no earlier dirty line is written back.
- R13: A memory command that is not yet accepted keeps `memCmdValid`, `memCmdWrite` and `memCmdAddr` unchanged until `memCmdReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Processor request, held until accepted |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Physical byte address |
| cpuByteEn | input | 8 | Store byte enables |
| cpuWData | input | 64 | Store data |
| cpuReady | output | 1 | Request completes at this clock edge |
| cpuRData | output | 64 | Load data, valid with cpuReady |
| memCmdValid | output | 1 | Memory command valid |
| memCmdWrite | output | 1 | 1 = line write-back, 0 = line refill |
| memCmdAddr | output | 32 | Line-aligned command address |
| memCmdReady | input | 1 | Memory accepts the command |
| memWrValid | output | 1 | Write-back beat valid |
| memWrData | output | 64 | Write-back beat data |
| memWrReady | input | 1 | Memory accepts the write beat |
| memRdValid | input | 1 | Refill beat valid |
| memRdData | input | 64 | Refill beat data |

## Verification
Two functions can land in the same cycle. The first is setting a way's access bit, which on the fourth distinct way of a set would saturate the set. The second is clearing the other three bits. Both happen in one register update. The bench fills all four ways of a set, touches a chosen way, and then forces misses. The write-back address of each dirty victim shows which bits survived, and it is compared with a reference model of valid, dirty, tag and access bits. Random loads and stores over a few crowded sets, with random memory back-pressure, also drive write-back bursts straight into refills. Those are judged by data read back against a reference memory and by the order of the commands.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITEBACK,
    ST_FILL,
    ST_RESPOND
  } missState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic access;       // hit commit: access bit, store merge, dirty
    logic latchVictim;  // capture chosen way and its tag
    logic fillBeat;     // write one refill beat into the victim way
    logic fillDone;     // last refill beat: install tag, valid, access bit
  } ctrlStrobe_t;

endpackage

// File: rtl/dcache_datapath.sv
module dcache_datapath
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 64,
  localparam int BE_W   = DATA_W / 8,
  localparam int BEATS  = LINE_BYTES / BE_W,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WOFF_W = $clog2(BE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strb,
  input  logic [BEAT_W-1:0] beatIdx,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic [BE_W-1:0]   cpuByteEn,
  input  logic [DATA_W-1:0] cpuWData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              hit,
  output logic [WAYS-1:0]   hitVec,
  output logic [DATA_W-1:0] rdData,
  output logic              victimDirtyNow,
  output logic [DATA_W-1:0] wbData,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [ADDR_W-1:0] fillAddr
);

  logic [SET_W-1:0]  setIdx;
  logic [TAG_W-1:0]  tagIn;
  logic [BEAT_W-1:0] wordIdx;

  assign setIdx  = cpuAddr[OFF_W +: SET_W];
  assign tagIn   = cpuAddr[ADDR_W-1 -: TAG_W];
  assign wordIdx = cpuAddr[WOFF_W +: BEAT_W];

  logic [TAG_W-1:0] tagArr   [WAYS][SETS];
  logic [WAYS-1:0]  validArr [SETS];
  logic [WAYS-1:0]  dirtyArr [SETS];
  logic [WAYS-1:0]  accArr   [SETS];

  logic [WAYS-1:0][DATA_W-1:0] wayWord;
  logic [WAYS-1:0][DATA_W-1:0] wbWord;

  logic [WAY_W-1:0] pickWay;
  logic [WAY_W-1:0] victimWay;
  logic [TAG_W-1:0] victimTag;
  logic [WAYS-1:0]  fillOneHot;

  assign fillOneHot = WAYS'(1) << victimWay;

  // Set the used way; on saturation keep only that way
  function automatic logic [WAYS-1:0] touch(input logic [WAYS-1:0] cur,
                                            input logic [WAYS-1:0] used);
    logic [WAYS-1:0] nxt;
    nxt = cur | used;
    return (&nxt) ? used : nxt;
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : gWay
    logic [DATA_W-1:0] lineMem [SETS*BEATS];

    assign hitVec[w]  = validArr[setIdx][w] && (tagArr[w][setIdx] == tagIn);
    assign wayWord[w] = lineMem[{setIdx, wordIdx}];
    assign wbWord[w]  = lineMem[{setIdx, beatIdx}];

    always_ff @(posedge clk) begin
      if (strb.fillBeat && victimWay == WAY_W'(w)) begin
        lineMem[{setIdx, beatIdx}] <= memRdData;
      end else if (strb.access && cpuWrite && hitVec[w]) begin
        for (int b = 0; b < BE_W; b++) begin
          if (cpuByteEn[b]) lineMem[{setIdx, wordIdx}][8*b +: 8] <= cpuWData[8*b +: 8];
        end
      end
    end
  end

  assign hit = |hitVec;

  always_comb begin
    rdData = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) rdData = rdData | wayWord[w];
    end
  end

  // Victim: lowest invalid way, else lowest way with a clear access bit
  always_comb begin
    logic found;
    found   = 1'b0;
    pickWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !validArr[setIdx][w]) begin
        pickWay = WAY_W'(w);
        found   = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !accArr[setIdx][w]) begin
        pickWay = WAY_W'(w);
        found   = 1'b1;
      end
    end
  end

  assign victimDirtyNow = validArr[setIdx][pickWay] && dirtyArr[setIdx][pickWay];

  always_ff @(posedge clk) begin
    if (rst) begin
      victimWay <= '0;
      victimTag <= '0;
    end else if (strb.latchVictim) begin
      victimWay <= pickWay;
      victimTag <= tagArr[pickWay][setIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillDone) tagArr[victimWay][setIdx] <= tagIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
        accArr[s]   <= '0;
      end
    end else if (strb.fillDone) begin
      validArr[setIdx][victimWay] <= 1'b1;
      dirtyArr[setIdx][victimWay] <= 1'b0;
      accArr[setIdx]              <= touch(accArr[setIdx], fillOneHot);
    end else if (strb.access) begin
      accArr[setIdx] <= touch(accArr[setIdx], hitVec);
      if (cpuWrite) dirtyArr[setIdx] <= dirtyArr[setIdx] | hitVec;
    end
  end

  assign wbData   = wbWord[victimWay];
  assign wbAddr   = {victimTag, setIdx, OFF_W'(0)};
  assign fillAddr = {tagIn, setIdx, OFF_W'(0)};

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int BEATS = 8,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              hit,
  input  logic              victimDirtyNow,
  input  logic              memCmdReady,
  input  logic              memWrReady,
  input  logic              memRdValid,
  output missState_t        state,
  output ctrlStrobe_t       strb,
  output logic [BEAT_W-1:0] beatIdx,
  output logic              cmdValid,
  output logic              cmdWrite,
  output logic              wrValid,
  output logic              cpuReady
);

  missState_t nextState;
  logic       cmdDone;
  logic       lastBeat;

  assign lastBeat = (beatIdx == BEAT_W'(BEATS - 1));

  always_comb begin
    strb      = '0;
    nextState = state;
    cmdValid  = 1'b0;
    cmdWrite  = 1'b0;
    wrValid   = 1'b0;
    cpuReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (hit) begin
            cpuReady    = 1'b1;
            strb.access = 1'b1;
          end else begin
            strb.latchVictim = 1'b1;
            nextState = victimDirtyNow ? ST_WRITEBACK : ST_FILL;
          end
        end
      end
      ST_WRITEBACK: begin
        cmdValid = !cmdDone;
        cmdWrite = 1'b1;
        wrValid  = cmdDone;
        if (cmdDone && memWrReady && lastBeat) nextState = ST_FILL;
      end
      ST_FILL: begin
        cmdValid      = !cmdDone;
        strb.fillBeat = cmdDone && memRdValid;
        strb.fillDone = cmdDone && memRdValid && lastBeat;
        if (strb.fillDone) nextState = ST_RESPOND;
      end
      ST_RESPOND: begin
        cpuReady    = cpuReq && hit;
        strb.access = cpuReq && hit;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cmdDone <= 1'b0;
      beatIdx <= '0;
    end else begin
      state <= nextState;
      if (state != nextState) begin
        cmdDone <= 1'b0;
        beatIdx <= '0;
      end else begin
        if (cmdValid && memCmdReady) cmdDone <= 1'b1;
        if ((wrValid && memWrReady) || strb.fillBeat) beatIdx <= beatIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dcache_top.sv
module dcache_top
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 64,
  localparam int BE_W   = DATA_W / 8,
  localparam int BEATS  = LINE_BYTES / BE_W,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [BE_W-1:0]   cpuByteEn,
  input  logic [DATA_W-1:0] cpuWData,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRData,
  output logic              memCmdValid,
  output logic              memCmdWrite,
  output logic [ADDR_W-1:0] memCmdAddr,
  input  logic              memCmdReady,
  output logic              memWrValid,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memWrReady,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData
);

  missState_t        state;
  ctrlStrobe_t       strb;
  logic [BEAT_W-1:0] beatIdx;
  logic              hit;
  logic [WAYS-1:0]   hitVec;
  logic              victimDirtyNow;
  logic [ADDR_W-1:0] wbAddr;
  logic [ADDR_W-1:0] fillAddr;

  dcache_ctrl #(.BEATS(BEATS)) ctrl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .hit(hit),
    .victimDirtyNow(victimDirtyNow), .memCmdReady(memCmdReady),
    .memWrReady(memWrReady), .memRdValid(memRdValid),
    .state(state), .strb(strb), .beatIdx(beatIdx),
    .cmdValid(memCmdValid), .cmdWrite(memCmdWrite),
    .wrValid(memWrValid), .cpuReady(cpuReady)
  );

  dcache_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS),
    .WAYS(WAYS), .LINE_BYTES(LINE_BYTES)
  ) dp (
    .clk(clk), .rst(rst), .strb(strb), .beatIdx(beatIdx),
    .cpuAddr(cpuAddr), .cpuWrite(cpuWrite), .cpuByteEn(cpuByteEn),
    .cpuWData(cpuWData), .memRdData(memRdData),
    .hit(hit), .hitVec(hitVec), .rdData(cpuRData),
    .victimDirtyNow(victimDirtyNow), .wbData(memWrData),
    .wbAddr(wbAddr), .fillAddr(fillAddr)
  );

  assign memCmdAddr = memCmdWrite ? wbAddr : fillAddr;

endmodule

// File: rtl/dcache_checker.sv
module dcache_checker
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4,
  parameter int BEATS  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReq,
  input logic              cpuReady,
  input missState_t        state,
  input logic [WAYS-1:0]   hitVec,
  input logic              memCmdValid,
  input logic              memCmdWrite,
  input logic [ADDR_W-1:0] memCmdAddr,
  input logic              memCmdReady,
  input logic              memWrValid,
  input logic              memWrReady
);

  logic       wbOpen;
  logic [7:0] wbCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbOpen  <= 1'b0;
      wbCount <= '0;
    end else begin
      if (memCmdValid && memCmdReady && memCmdWrite) begin
        wbOpen  <= 1'b1;
        wbCount <= '0;
      end else if (memWrValid && memWrReady) begin
        wbCount <= wbCount + 8'd1;
      end
      if (memCmdValid && memCmdReady && !memCmdWrite) wbOpen <= 1'b0;
    end
  end

  AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitVec)); // R1

  AST_NO_READY_IN_MISS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITEBACK || state == ST_FILL) |-> !cpuReady); // R4

  AST_RESPOND_HITS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESPOND && cpuReq) |-> cpuReady); // R6

  AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
    (memCmdValid && !memCmdWrite && wbOpen) |-> (wbCount == 8'(BEATS))); // R7

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    (memCmdValid && !memCmdReady) |=>
      (memCmdValid && $stable(memCmdAddr) && $stable(memCmdWrite))); // R13

endmodule

bind dcache_top dcache_checker #(.ADDR_W(32), .WAYS(4), .BEATS(8)) chk (
  .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuReady(cpuReady),
  .state(state), .hitVec(hitVec), .memCmdValid(memCmdValid),
  .memCmdWrite(memCmdWrite), .memCmdAddr(memCmdAddr),
  .memCmdReady(memCmdReady), .memWrValid(memWrValid),
  .memWrReady(memWrReady)
);

// File: tb/dcache_top_test.sv
module dcache_top_test;

  localparam int PERIOD = 8;  // 125 MHz

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [7:0]  cpuByteEn = '0;
  logic [63:0] cpuWData = '0;
  logic        cpuReady;
  logic [63:0] cpuRData;
  logic        memCmdValid, memCmdWrite, memWrValid;
  logic [31:0] memCmdAddr;
  logic [63:0] memWrData;
  logic        memCmdReady = 1'b0, memWrReady = 1'b0, memRdValid = 1'b0;
  logic [63:0] memRdData = '0;

  always #(PERIOD/2) clk = ~clk;

  dcache_top uut (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuByteEn(cpuByteEn), .cpuWData(cpuWData),
    .cpuReady(cpuReady), .cpuRData(cpuRData),
    .memCmdValid(memCmdValid), .memCmdWrite(memCmdWrite),
    .memCmdAddr(memCmdAddr), .memCmdReady(memCmdReady),
    .memWrValid(memWrValid), .memWrData(memWrData), .memWrReady(memWrReady),
    .memRdValid(memRdValid), .memRdData(memRdData)
  );

  int errors = 0;
  int checks = 0;

  logic [63:0] mem    [0:8191];
  logic [63:0] refMem [0:8191];

  logic [18:0] mTag   [0:127][0:3];
  bit          mValid [0:127][0:3];
  bit          mDirty [0:127][0:3];
  bit          mAcc   [0:127][0:3];

  int          wbCmds = 0, fillCmds = 0, holdViol = 0, orderViol = 0;
  logic [31:0] lastWbAddr = '0, lastFillAddr = '0;
  int          wbWord = 0, wbBeat = 0, fillWord = 0, fillBeat = 0;
  bit          wbOpen = 0, fillPend = 0, prevWait = 0, prevWrite = 0;
  logic [31:0] prevAddr = '0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkAddr(int tag, int set, int word);
    return {16'h0, 3'(tag), 7'(set), 3'(word), 3'b000};
  endfunction

  function automatic int pickVictim(int s);
    for (int w = 0; w < 4; w++) if (!mValid[s][w]) return w;
    for (int w = 0; w < 4; w++) if (!mAcc[s][w]) return w;
    return 0;
  endfunction

  function automatic void touchModel(int s, int w);
    bit full;
    mAcc[s][w] = 1'b1;
    full = 1'b1;
    for (int k = 0; k < 4; k++) if (!mAcc[s][k]) full = 1'b0;
    if (full) for (int k = 0; k < 4; k++) mAcc[s][k] = (k == w);
  endfunction

  function automatic void clearModel();
    for (int s = 0; s < 128; s++)
      for (int w = 0; w < 4; w++) begin
        mValid[s][w] = 0; mDirty[s][w] = 0; mAcc[s][w] = 0; mTag[s][w] = '0;
      end
  endfunction

  // Memory side responder with random back-pressure
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        memRdValid = 0; memCmdReady = 0; memWrReady = 0;
        fillPend = 0; wbOpen = 0; prevWait = 0;
      end else begin
        if (prevWait && !(memCmdValid && memCmdAddr == prevAddr && memCmdWrite == prevWrite))
          holdViol++;
        memRdValid = 0;
        if (fillPend && $urandom_range(0, 3) != 0) begin
          memRdValid = 1;
          memRdData  = mem[fillWord + fillBeat];
          fillBeat++;
          if (fillBeat == 8) fillPend = 0;
        end
        memWrReady = ($urandom_range(0, 3) != 0);
        if (memWrValid && memWrReady) begin
          mem[wbWord + wbBeat] = memWrData;
          wbBeat++;
          if (wbBeat == 8) wbOpen = 0;
        end
        memCmdReady = ($urandom_range(0, 2) != 0);
        prevWait  = memCmdValid && !memCmdReady;
        prevAddr  = memCmdAddr;
        prevWrite = memCmdWrite;
        if (memCmdValid && memCmdReady) begin
          if (memCmdWrite) begin
            wbCmds++; lastWbAddr = memCmdAddr;
            wbWord = int'(memCmdAddr[15:3]); wbBeat = 0; wbOpen = 1;
          end else begin
            fillCmds++; lastFillAddr = memCmdAddr;
            if (wbOpen) orderViol++;
            fillWord = int'(memCmdAddr[15:3]); fillBeat = 0; fillPend = 1;
          end
        end
      end
    end
  end

  task automatic access(bit wr, logic [31:0] addr, logic [7:0] be, logic [63:0] wd,
                        string vicLbl, string datLbl);
    int s, hw, v, waited, wb0, f0, idx;
    logic [18:0] tag;
    bit expHit, expWb, hitObs;
    logic [31:0] expWbAddr;
    logic [63:0] rd;
    s = int'(addr[12:6]); tag = addr[31:13]; idx = int'(addr[15:3]);
    hw = -1; expWb = 0; expWbAddr = '0; v = 0;
    for (int w = 0; w < 4; w++) if (mValid[s][w] && mTag[s][w] == tag) hw = w;
    expHit = (hw >= 0);
    if (!expHit) begin
      v = pickVictim(s);
      expWb = mValid[s][v] && mDirty[s][v];
      expWbAddr = {mTag[s][v], 7'(s), 6'b0};
    end
    wb0 = wbCmds; f0 = fillCmds;
    @(negedge clk);
    cpuReq = 1; cpuWrite = wr; cpuAddr = addr; cpuByteEn = be; cpuWData = wd;
    #1;
    waited = 0;
    while (!cpuReady && waited < 400) begin
      @(negedge clk); #1; waited++;
    end
    rd = cpuRData;
    hitObs = (waited == 0);
    if (waited >= 400) check(0, "R4", "request never completed", 64'(waited), 64'd0);
    @(posedge clk); #1;
    cpuReq = 0;
    check(hitObs == expHit, expHit ? "R2" : "R4", "hit on first cycle", 64'(hitObs), 64'(expHit));
    if (!expHit) begin
      check(fillCmds == f0 + 1 && lastFillAddr == {addr[31:6], 6'b0}, "R6", "refill command",
            64'(lastFillAddr), 64'({addr[31:6], 6'b0}));
      if (expWb)
        check(wbCmds == wb0 + 1 && lastWbAddr == expWbAddr, vicLbl, "write-back victim address",
              64'(lastWbAddr), 64'(expWbAddr));
      else
        check(wbCmds == wb0, "R8", "no write-back for clean victim", 64'(wbCmds - wb0), 64'd0);
      mValid[s][v] = 1; mTag[s][v] = tag; mDirty[s][v] = 0;
      touchModel(s, v);
      hw = v;
    end else begin
      check(wbCmds == wb0 && fillCmds == f0, wr ? "R3" : "R2", "no memory traffic on hit",
            64'((wbCmds - wb0) + (fillCmds - f0)), 64'd0);
    end
    if (!wr) check(rd == refMem[idx], datLbl, "load data", rd, refMem[idx]);
    touchModel(s, hw);
    if (wr) begin
      mDirty[s][hw] = 1;
      for (int b = 0; b < 8; b++) if (be[b]) refMem[idx][8*b +: 8] = wd[8*b +: 8];
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 8192; i++) refMem[i] = mem[i];
    clearModel();
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; errors++;
    $display("FAIL R4 watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int wb0, pool[5];
    pool = '{0, 1, 9, 64, 127};
    void'($urandom(32'd2024));
    for (int i = 0; i < 8192; i++) begin
      mem[i]    = 64'(i) * 64'h9E37_79B9_7F4A_7C15 ^ 64'h0F0F_1234_5678_ABCD;
      refMem[i] = mem[i];
    end
    clearModel();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cpuReady == 0 && memCmdValid == 0 && memWrValid == 0, "R12", "outputs idle in reset",
          {61'd0, cpuReady, memCmdValid, memWrValid}, 64'd0);
    rst = 0;

    // Empty set fills ways in order (R9), then saturation and scan
    for (int t = 0; t < 4; t++) access(0, mkAddr(t, 9, t), 8'hFF, '0, "R9", "R2");
    for (int t = 0; t < 4; t++) access(1, mkAddr(t, 9, 1), 8'hFF, 64'hA5A5_0000_0000_0000 + 64'(t), "R9", "R2");
    access(0, mkAddr(0, 9, 1), 8'hFF, '0, "R10", "R3");
    access(0, mkAddr(4, 9, 2), 8'hFF, '0, "R11", "R2");
    access(0, mkAddr(5, 9, 3), 8'hFF, '0, "R10", "R2");
    access(0, mkAddr(6, 9, 0), 8'hFF, '0, "R11", "R2");
    access(0, mkAddr(7, 9, 4), 8'hFF, '0, "R10", "R2");
    for (int t = 0; t < 4; t++) access(0, mkAddr(t, 9, 1), 8'hFF, '0, "R7", "R7");

    // Partial store on a hit and on a miss
    access(0, mkAddr(2, 20, 5), 8'hFF, '0, "R7", "R2");
    access(1, mkAddr(2, 20, 5), 8'h3C, 64'h1122_3344_5566_7788, "R7", "R3");
    access(0, mkAddr(2, 20, 5), 8'hFF, '0, "R7", "R3");
    access(1, mkAddr(3, 21, 6), 8'h0F, 64'hDEAD_BEEF_CAFE_F00D, "R7", "R5");
    access(0, mkAddr(3, 21, 6), 8'hFF, '0, "R7", "R5");
    access(0, mkAddr(3, 21, 7), 8'hFF, '0, "R7", "R5");

    // Top set and top tag bits
    access(0, mkAddr(7, 127, 7), 8'hFF, '0, "R7", "R2");
    check(lastFillAddr == 32'h0000_FFC0, "R1", "set and tag placement", 64'(lastFillAddr), 64'h0000_FFC0);

    // Random traffic over crowded sets
    for (int n = 0; n < 700; n++) begin
      int tg, st, wd;
      bit wr;
      tg = $urandom_range(0, 7);
      st = pool[$urandom_range(0, 4)];
      wd = $urandom_range(0, 7);
      wr = $urandom_range(0, 1);
      access(wr, mkAddr(tg, st, wd), 8'($urandom), {$urandom, $urandom}, "R7", "R2");
    end

    // Mid-run reset drops dirty lines without write-back
    for (int t = 0; t < 4; t++) access(1, mkAddr(t, 9, 0), 8'hFF, 64'(t) + 64'h77, "R7", "R2");
    applyReset();
    wb0 = wbCmds;
    for (int t = 0; t < 4; t++) access(0, mkAddr(t, 9, 0), 8'hFF, '0, "R9", "R12");
    check(wbCmds == wb0, "R12", "no write-back after reset", 64'(wbCmds - wb0), 64'd0);

    check(holdViol == 0, "R13", "command held until accepted", 64'(holdViol), 64'd0);
    check(orderViol == 0, "R7", "write-back beats done before refill", 64'(orderViol), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule